// File: doc/BRIEF.md
# Single-Wire Open-Drain Half-Duplex Transceiver

This block carries asynchronous byte frames over one shared wire that an external resistor pulls high. Its transmitter can only pull the wire low, through a drive-enable output that controls an open-drain pad. For a logic 1 the transmitter lets go of the wire, and the resistor brings it back high. The receiver watches the sampled wire and begins a frame when the wire falls. The same wire can carry UART-style links and K-line style diagnostic buses. Only one node may talk at a time, and a higher-level protocol must ensure this.

Each frame has one low start bit, then eight data bits with the least significant bit first, then one high stop bit. Every bit lasts `CLKS_PER_BIT` system clocks. While the local transmitter is busy, and for one further bit period after its stop bit, the receiver sees a forced idle-high level. This blanking keeps the node from decoding its own traffic and covers the slow rise of the pulled-up wire. Setting the `BLANK_EN` parameter to 0 removes the blanking, so the node receives its own frames back for self-test.

Top module: `swire_xcvr`

## Requirements
- R1: `lineDriveLow` is 1 only during the start bit and during data bits equal to 0. At all other times it is 0, which releases the wire. The block has no way to drive the wire high.
- R2: A byte is accepted at a clock edge where `txValid` and `txReady` are both 1. The frame starts on the following cycle. Bit b of the frame (0 = start, 1..8 = data bit b-1, 9 = stop) occupies cycles b*N to b*N+N-1, where N is `CLKS_PER_BIT`.
- R3: `txReady` is 1 when the transmitter is idle. It goes to 0 at the accepting edge and stays 0 until the end of the stop bit, which is 10*N cycles later. It is 1 again after that.
- R4: An incoming 8N1 frame on `lineIn`, sampled at mid-bit with the least significant bit first, produces a one-cycle `rxValid` pulse, and `rxData` holds the byte.
- R5: A low pulse on an idle wire that is shorter than half a bit period fails the mid-start check. It produces neither `rxValid` nor `rxFrameErr`.
- R6: If the stop bit samples low, `rxFrameErr` pulses for one cycle and `rxValid` stays 0. The two pulses never occur together.
- R7: With `BLANK_EN`=1, the node's own transmission on the shared wire produces no `rxValid` and no `rxFrameErr`.
- R8: With `BLANK_EN`=1, the receiver keeps seeing idle high for N cycles after the stop bit ends. A low pulse on the wire inside that window is ignored.
- R9: With `BLANK_EN`=0, a node whose wire carries only its own drive receives each byte it sends.
- R10: After reset, `txReady`=1, `lineDriveLow`=0, `rxValid`=0 and `rxFrameErr`=0. A wire held high (released) yields no receive events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| txValid | input | 1 | A byte is offered for transmission |
| txData | input | DATA_BITS | Byte to transmit |
| txReady | output | 1 | The transmitter can accept a byte |
| rxValid | output | 1 | One-cycle pulse: `rxData` holds a received byte |
| rxData | output | DATA_BITS | Last correctly framed byte |
| rxFrameErr | output | 1 | One-cycle pulse: the stop bit sampled low |
| lineDriveLow | output | 1 | 1 = pull the wire low; 0 = release the wire |
| lineIn | input | 1 | Sampled level of the shared wire |

## Verification
The receiver is fed random bytes from a modelled remote node. These frames separate correct bit order and mid-bit sampling from off-by-one timing faults. Frames with a low stop bit are mixed in to tell the framing-error path apart from normal delivery. Short low glitches on an idle wire, of 3 and 6 cycles, check that the mid-start check rejects noise. A 12-cycle low pulse placed just after the node's own stop bit tells the extended blanking window apart from blanking that ends with the stop bit. A second instance with blanking disabled sends each byte and must receive it back, which shows that the blanking parameter selects the right variant.

// File: rtl/swire_pkg.sv
package swire_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_START = 2'd1,
    PH_DATA  = 2'd2,
    PH_STOP  = 2'd3
  } phase_e;

  // strobes from control to datapath; all decoded from control registers
  typedef struct packed {
    logic txLoad;      // capture the offered byte
    logic txShift;     // advance to the next outgoing bit
    logic driveStart;  // start bit in progress
    logic driveData;   // data bits in progress
    logic rxShift;     // take a mid-bit sample into the receive shifter
    logic rxStopEnd;   // stop bit sample point
  } swCtl_t;

endpackage

// File: rtl/swire_ctrl.sv
module swire_ctrl
  import swire_pkg::*;
#(
  parameter int CLKS_PER_BIT = 16,
  parameter int DATA_BITS    = 8
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   txValid,
  input  logic   rxBit,
  output logic   txReady,
  output logic   rxBlank,
  output swCtl_t ctl
);

  localparam int TW   = $clog2(CLKS_PER_BIT);
  localparam int IW   = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
  localparam int HALF = CLKS_PER_BIT / 2;
  localparam logic [TW-1:0] BIT_LAST  = TW'(CLKS_PER_BIT - 1);
  localparam logic [TW-1:0] HALF_LAST = TW'(HALF - 1);
  localparam logic [IW-1:0] IDX_LAST  = IW'(DATA_BITS - 1);

  phase_e          txPh, rxPh;
  logic [TW-1:0]   txTmr, rxTmr, tailTmr;
  logic [IW-1:0]   txIdx, rxIdx;
  logic            tailOn;
  logic            txBitEnd, rxBitEnd;

  assign txBitEnd = (txTmr == BIT_LAST);
  assign rxBitEnd = (rxTmr == BIT_LAST);

  // transmit sequencing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txPh  <= PH_IDLE;
      txTmr <= '0;
      txIdx <= '0;
    end else begin
      case (txPh)
        PH_IDLE: begin
          if (txValid) begin
            txPh  <= PH_START;
            txTmr <= '0;
          end
        end
        PH_START: begin
          if (txBitEnd) begin
            txPh  <= PH_DATA;
            txTmr <= '0;
            txIdx <= '0;
          end else begin
            txTmr <= txTmr + 1'b1;
          end
        end
        PH_DATA: begin
          if (txBitEnd) begin
            txTmr <= '0;
            if (txIdx == IDX_LAST) txPh <= PH_STOP;
            else                   txIdx <= txIdx + 1'b1;
          end else begin
            txTmr <= txTmr + 1'b1;
          end
        end
        default: begin
          if (txBitEnd) begin
            txPh  <= PH_IDLE;
            txTmr <= '0;
          end else begin
            txTmr <= txTmr + 1'b1;
          end
        end
      endcase
    end
  end

  // extra bit period of blanking while the pulled-up wire recovers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tailOn  <= 1'b0;
      tailTmr <= '0;
    end else if (txPh == PH_STOP && txBitEnd) begin
      tailOn  <= 1'b1;
      tailTmr <= '0;
    end else if (tailOn) begin
      if (tailTmr == BIT_LAST) tailOn <= 1'b0;
      else                     tailTmr <= tailTmr + 1'b1;
    end
  end

  // receive sequencing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxPh  <= PH_IDLE;
      rxTmr <= '0;
      rxIdx <= '0;
    end else begin
      case (rxPh)
        PH_IDLE: begin
          if (!rxBit) begin
            rxPh  <= PH_START;
            rxTmr <= '0;
          end
        end
        PH_START: begin
          if (rxTmr == HALF_LAST) begin
            rxTmr <= '0;
            rxIdx <= '0;
            rxPh  <= rxBit ? PH_IDLE : PH_DATA;
          end else begin
            rxTmr <= rxTmr + 1'b1;
          end
        end
        PH_DATA: begin
          if (rxBitEnd) begin
            rxTmr <= '0;
            if (rxIdx == IDX_LAST) rxPh <= PH_STOP;
            else                   rxIdx <= rxIdx + 1'b1;
          end else begin
            rxTmr <= rxTmr + 1'b1;
          end
        end
        default: begin
          if (rxBitEnd) begin
            rxPh  <= PH_IDLE;
            rxTmr <= '0;
          end else begin
            rxTmr <= rxTmr + 1'b1;
          end
        end
      endcase
    end
  end

  assign txReady = (txPh == PH_IDLE);
  assign rxBlank = (txPh != PH_IDLE) || tailOn;

  always_comb begin
    ctl            = '0;
    ctl.txLoad     = (txPh == PH_IDLE) && txValid;
    ctl.txShift    = (txPh == PH_DATA) && txBitEnd;
    ctl.driveStart = (txPh == PH_START);
    ctl.driveData  = (txPh == PH_DATA);
    ctl.rxShift    = (rxPh == PH_DATA) && rxBitEnd;
    ctl.rxStopEnd  = (rxPh == PH_STOP) && rxBitEnd;
  end

endmodule

// File: rtl/swire_dp.sv
module swire_dp
  import swire_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter bit BLANK_EN  = 1'b1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  swCtl_t               ctl,
  input  logic                 rxBlank,
  input  logic [DATA_BITS-1:0] txData,
  input  logic                 lineIn,
  output logic                 rxBit,
  output logic                 lineDriveLow,
  output logic                 rxValid,
  output logic [DATA_BITS-1:0] rxData,
  output logic                 rxFrameErr
);

  logic                 syncA, syncB;
  logic [DATA_BITS-1:0] txSh, rxSh;

  // two-stage synchronizer, idle-high after reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= 1'b1;
      syncB <= 1'b1;
    end else begin
      syncA <= lineIn;
      syncB <= syncA;
    end
  end

  generate
    if (BLANK_EN) begin : g_blank
      assign rxBit = rxBlank ? 1'b1 : syncB;
    end else begin : g_loop
      logic unusedBlank;
      assign unusedBlank = rxBlank;
      assign rxBit = syncB;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txSh <= '0;
    end else if (ctl.txLoad) begin
      txSh <= txData;
    end else if (ctl.txShift) begin
      txSh <= {1'b0, txSh[DATA_BITS-1:1]};
    end
  end

  assign lineDriveLow = ctl.driveStart | (ctl.driveData & ~txSh[0]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSh       <= '0;
      rxData     <= '0;
      rxValid    <= 1'b0;
      rxFrameErr <= 1'b0;
    end else begin
      if (ctl.rxShift) rxSh <= {rxBit, rxSh[DATA_BITS-1:1]};
      if (ctl.rxStopEnd && rxBit) rxData <= rxSh;
      rxValid    <= ctl.rxStopEnd & rxBit;
      rxFrameErr <= ctl.rxStopEnd & ~rxBit;
    end
  end

endmodule

// File: rtl/swire_xcvr.sv
module swire_xcvr
  import swire_pkg::*;
#(
  parameter int CLKS_PER_BIT = 16,
  parameter int DATA_BITS    = 8,
  parameter bit BLANK_EN     = 1'b1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 txValid,
  input  logic [DATA_BITS-1:0] txData,
  output logic                 txReady,
  output logic                 rxValid,
  output logic [DATA_BITS-1:0] rxData,
  output logic                 rxFrameErr,
  output logic                 lineDriveLow,
  input  logic                 lineIn
);

  swCtl_t ctl;
  logic   rxBit;
  logic   rxBlank;

  swire_ctrl #(
    .CLKS_PER_BIT(CLKS_PER_BIT),
    .DATA_BITS   (DATA_BITS)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .txValid(txValid),
    .rxBit  (rxBit),
    .txReady(txReady),
    .rxBlank(rxBlank),
    .ctl    (ctl)
  );

  swire_dp #(
    .DATA_BITS(DATA_BITS),
    .BLANK_EN (BLANK_EN)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .rxBlank     (rxBlank),
    .txData      (txData),
    .lineIn      (lineIn),
    .rxBit       (rxBit),
    .lineDriveLow(lineDriveLow),
    .rxValid     (rxValid),
    .rxData      (rxData),
    .rxFrameErr  (rxFrameErr)
  );

endmodule

// File: rtl/swire_xcvr_chk.sv
module swire_xcvr_chk (
  input logic clk,
  input logic rstN,
  input logic txValid,
  input logic txReady,
  input logic rxValid,
  input logic rxFrameErr,
  input logic lineDriveLow
);

  // R1
  drive_only_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    lineDriveLow |-> !txReady);

  // R3
  ready_drops_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady) |=> !txReady);

  // R4
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  // R6
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxFrameErr |=> !rxFrameErr);

  // R6
  no_valid_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(rxValid && rxFrameErr));

endmodule

bind swire_xcvr swire_xcvr_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .txValid     (txValid),
  .txReady     (txReady),
  .rxValid     (rxValid),
  .rxFrameErr  (rxFrameErr),
  .lineDriveLow(lineDriveLow)
);

// File: tb/tb_swire_xcvr.sv
module tb_swire_xcvr;

  localparam int N = 16;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       txValid = 1'b0;
  logic [7:0] txData = '0;
  logic       remLow = 1'b0;

  logic       txReady, rxValid, rxFrameErr, drvLow;
  logic [7:0] rxData;
  logic       lTxReady, lRxValid, lRxFrameErr, lDrvLow;
  logic [7:0] lRxData;
  logic       line, lLine;

  int checks = 0;
  int errors = 0;
  int vCnt = 0, eCnt = 0, lvCnt = 0;
  logic [7:0] lastRx = '0, lastLoop = '0;

  always #2.5 clk = ~clk;

  // wired-AND shared wire with pull-up: released reads as 1
  assign line  = ~(drvLow | remLow);
  assign lLine = ~lDrvLow;

  swire_xcvr #(.CLKS_PER_BIT(N), .DATA_BITS(8), .BLANK_EN(1'b1)) dut (
    .clk(clk), .rstN(rstN), .txValid(txValid), .txData(txData),
    .txReady(txReady), .rxValid(rxValid), .rxData(rxData),
    .rxFrameErr(rxFrameErr), .lineDriveLow(drvLow), .lineIn(line));

  swire_xcvr #(.CLKS_PER_BIT(N), .DATA_BITS(8), .BLANK_EN(1'b0)) dutLoop (
    .clk(clk), .rstN(rstN), .txValid(txValid), .txData(txData),
    .txReady(lTxReady), .rxValid(lRxValid), .rxData(lRxData),
    .rxFrameErr(lRxFrameErr), .lineDriveLow(lDrvLow), .lineIn(lLine));

  always @(negedge clk) begin
    if (rstN) begin
      if (rxValid) begin vCnt++; lastRx = rxData; end
      if (rxFrameErr) eCnt++;
      if (lRxValid) begin lvCnt++; lastLoop = lRxData; end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit frameBit(input logic [7:0] d, input int b, input bit badStop);
    if (b == 0) return 1'b0;
    if (b <= 8) return d[b-1];
    return !badStop;
  endfunction

  task automatic remoteSend(input logic [7:0] d, input bit badStop);
    int v0 = vCnt;
    int e0 = eCnt;
    for (int b = 0; b < 10; b++) begin
      remLow = !frameBit(d, b, badStop);
      repeat (N) @(negedge clk);
    end
    remLow = 1'b0;
    repeat (N) @(negedge clk);
    if (badStop) begin
      chk(eCnt == e0 + 1, "R6 err count", eCnt - e0, 1);
      chk(vCnt == v0, "R6 no valid", vCnt - v0, 0);
    end else begin
      chk(vCnt == v0 + 1 && lastRx == d, "R4 rx byte", lastRx, d);
      chk(eCnt == e0, "R4 no err", eCnt - e0, 0);
    end
  endtask

  // own transmit: checks wire drive per bit and the ready window
  task automatic nodeSend(input logic [7:0] d);
    int v0 = vCnt;
    int e0 = eCnt;
    int l0 = lvCnt;
    bit bitsOk = 1'b1;
    bit rdyOk = 1'b1;
    @(negedge clk);
    txValid = 1'b1;
    txData  = d;
    @(posedge clk);
    @(negedge clk);
    txValid = 1'b0;
    for (int k = 0; k < 10 * N; k++) begin
      if (k % N == N / 2) begin
        if (drvLow != !frameBit(d, k / N, 1'b0)) begin
          bitsOk = 1'b0;
          chk(1'b0, "R1 R2 drive bit", drvLow, !frameBit(d, k / N, 1'b0));
        end
      end
      if (txReady) rdyOk = 1'b0;
      @(negedge clk);
    end
    chk(bitsOk, "R1 R2 frame bits", bitsOk, 1);
    chk(rdyOk, "R3 ready low in frame", rdyOk, 1);
    chk(txReady == 1'b1, "R3 ready after stop", txReady, 1);
    repeat (2 * N) @(negedge clk);
    chk(vCnt == v0 && eCnt == e0, "R7 no self echo", vCnt - v0 + eCnt - e0, 0);
    chk(lvCnt == l0 + 1 && lastLoop == d, "R9 loopback byte", lastLoop, d);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int v0, e0;
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(txReady == 1'b1, "R10 ready", txReady, 1);
    chk(drvLow == 1'b0, "R10 released", drvLow, 0);
    chk(rxValid == 1'b0 && rxFrameErr == 1'b0, "R10 rx quiet", rxValid, 0);
    rstN = 1'b1;
    repeat (4 * N) @(negedge clk);
    chk(vCnt == 0 && eCnt == 0, "R10 idle line", vCnt + eCnt, 0);

    // directed frames
    remoteSend(8'h00, 1'b0);
    remoteSend(8'hFF, 1'b0);
    remoteSend(8'h01, 1'b0);
    remoteSend(8'h80, 1'b0);
    remoteSend(8'hA5, 1'b1);
    remoteSend(8'h3C, 1'b0);

    // R5 short glitches
    v0 = vCnt; e0 = eCnt;
    remLow = 1'b1; repeat (3) @(negedge clk); remLow = 1'b0;
    repeat (2 * N) @(negedge clk);
    remLow = 1'b1; repeat (6) @(negedge clk); remLow = 1'b0;
    repeat (12 * N) @(negedge clk);
    chk(vCnt == v0 && eCnt == e0, "R5 glitch ignored", vCnt - v0 + eCnt - e0, 0);

    // own transmissions
    nodeSend(8'h55);
    nodeSend(8'h00);

    // R8: pulse inside the post-stop window
    @(negedge clk);
    txValid = 1'b1; txData = 8'hC3;
    @(posedge clk);
    @(negedge clk);
    txValid = 1'b0;
    v0 = vCnt; e0 = eCnt;
    repeat (10 * N) @(negedge clk);
    remLow = 1'b1; repeat (12) @(negedge clk); remLow = 1'b0;
    repeat (14 * N) @(negedge clk);
    chk(vCnt == v0 && eCnt == e0, "R8 tail blank", vCnt - v0 + eCnt - e0, 0);

    // random mix
    for (int i = 0; i < 20; i++) begin
      logic [7:0] d;
      d = 8'($urandom());
      remoteSend(d, ($urandom() % 6) == 0);
      if (i % 5 == 4) nodeSend(8'($urandom()));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule